// File: doc/BRIEF.md
# Linked-Descriptor Scatter-Gather DMA Engine

This block moves a data transfer between system memory and a card data port by walking a chain of descriptors held in memory. Each descriptor is four 32-bit little-endian words. Word 0 is status, word 1 is the buffer size in bytes, word 2 is the buffer address and word 3 is the address of the next descriptor. The engine is started with a descriptor base address, a total byte count, a block size, a direction and an enable. It then visits descriptors in turn and streams bytes between each buffer and the card port. After each buffer it writes the descriptor back with the ownership bit cleared. It stops when the byte count runs out or a descriptor flagged as last has been handled.

On the memory side it is a word-wide master. Each beat is held until it is acknowledged, and data beats are grouped into bursts whose first beat carries the burst length. On the card side it uses a byte-wide valid/ready stream for each direction. When the walk ends it raises a one-cycle done pulse and a set of completion flags, which stay set until the next accepted start.

Top module: `sg_dma_walker`

## Requirements
- R1: The engine follows the next-descriptor address (word 3) from one descriptor to the next. It stops after a descriptor whose status bit 2 (last) is set, and never writes back a descriptor it did not visit.
- R2: Each descriptor moves the smaller of its effective size and the bytes remaining. When the remaining count reaches zero the walk ends, even if the last flag is clear. The total moved is the smaller of the programmed count and the sum of the effective sizes.
- R3: A size word of 0 means MAX_DESC bytes. A size word above MAX_DESC is treated as MAX_DESC.
- R4: Bits 1:0 of the buffer address are ignored. Data beats start at the word-aligned address and step by 4 bytes. Every memory request address is word-aligned, and a request is held stable until acknowledged.
- R5: After a buffer is moved, the engine writes status with bit 31 cleared to word 0 and the effective (clamped) size to word 1. Words 2 and 3 are left unchanged.
- R6: A start is ignored when enable is low, when the byte count is zero or when the block size is zero. Busy stays low and no memory request is made.
- R7: For card-to-memory transfers (cfg_to_card = 0), an accepted start sets busy but makes no memory request until card_rdy is high.
- R8: Memory-to-card transfers (cfg_to_card = 1) send the bytes of each word least significant byte first (bits 7:0 first). The last word of a buffer sends only the bytes that remain.
- R9: Card-to-memory transfers pack received bytes least significant byte first. Each write enables only the bytes moved, so bytes after the end of a buffer in its last word stay unchanged.
- R10: At the end of a walk, done pulses for one cycle and busy falls. The flags data-complete, SDIO event and DMA summary are set, plus flag_tx for memory-to-card or flag_rx for card-to-memory. All flags clear on the next accepted start.
- R11: A start that arrives while busy is ignored. Configuration is captured only when a start is accepted.
- R12: Descriptor header and writeback beats are single-beat bursts. Data beats form bursts of min(words left in the buffer, BURST_BYTES/4) beats, and the first beat of each burst is flagged and carries that length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| cfg_en | input | 1 | DMA enable |
| cfg_base | input | 32 | Address of the first descriptor |
| cfg_bytes | input | 32 | Total bytes to move |
| cfg_blksz | input | BLKW | Block size; zero blocks the start |
| cfg_to_card | input | 1 | 1 = memory to card, 0 = card to memory |
| card_rdy | input | 1 | Card has read data available |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_bfirst | output | 1 | First beat of a burst |
| mem_blen | output | LW | Burst length in beats, valid with mem_bfirst |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte to card valid |
| tx_data | output | 8 | Byte to card |
| tx_ready | input | 1 | Card accepts byte |
| rx_valid | input | 1 | Byte from card valid |
| rx_data | input | 8 | Byte from card |
| rx_ready | output | 1 | Engine accepts byte |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| flag_data | output | 1 | Data-complete flag |
| flag_sdio | output | 1 | SDIO event flag |
| flag_sum | output | 1 | DMA summary flag |
| flag_tx | output | 1 | Memory-to-card done flag |
| flag_rx | output | 1 | Card-to-memory done flag |

## Verification
A wrong remaining count or effective size shows up within one descriptor. The byte stream on the card port or in memory becomes too long or too short, and word 1 of the writeback holds the wrong value. A broken chain pointer or a missed last flag leaves the ownership bit set on a descriptor that should have been visited, or clears it on one that should not, and this is visible in memory once done pulses. Burst bookkeeping errors appear as a mismatch between the sum of burst lengths and the beats actually acknowledged, which is counted over each whole run.

// File: rtl/sg_dma_walker.sv
module sg_dma_walker #(
  parameter int MAX_DESC    = 8192,
  parameter int BURST_BYTES = 1024,
  parameter int BLKW        = 16,
  localparam int BEATS      = BURST_BYTES / 4,
  localparam int LW         = $clog2(BEATS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cfg_en,
  input  logic [31:0]     cfg_base,
  input  logic [31:0]     cfg_bytes,
  input  logic [BLKW-1:0] cfg_blksz,
  input  logic            cfg_to_card,
  input  logic            card_rdy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  output logic            mem_bfirst,
  output logic [LW-1:0]   mem_blen,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  input  logic            tx_ready,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            busy,
  output logic            done,
  output logic            flag_data,
  output logic            flag_sdio,
  output logic            flag_sum,
  output logic            flag_tx,
  output logic            flag_rx
);
  localparam logic [31:0] MAXV = 32'(MAX_DESC);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_HDR, S_RD, S_TX, S_RX, S_WR, S_WB0, S_WB1
  } state_t;

  state_t      state;
  logic [31:0] daddr, rem, st_w, sz_w, ba_w, nx_w, xfer, dn, wbuf;
  logic [1:0]  hidx, bidx;
  logic [LW-1:0] bcnt;
  logic        dir;

  logic [31:0] left, wleft, dn_nx;
  logic [2:0]  nb;
  logic [LW-1:0] blen_d;
  logic        data_beat, go, last_byte;

  assign left      = xfer - dn;
  assign nb        = (left >= 32'd4) ? 3'd4 : left[2:0];
  assign wleft     = (left + 32'd3) >> 2;
  assign blen_d    = (wleft > 32'(BEATS)) ? LW'(BEATS) : wleft[LW-1:0];
  assign dn_nx     = dn + {29'd0, nb};
  assign last_byte = ({1'b0, bidx} == nb - 3'd1);
  assign data_beat = (state == S_RD) || (state == S_WR);
  assign go        = start && (state == S_IDLE) && cfg_en &&
                     (cfg_bytes != 32'd0) && (cfg_blksz != '0);

  assign mem_req    = (state == S_HDR) || data_beat || (state == S_WB0) || (state == S_WB1);
  assign mem_we     = (state == S_WR) || (state == S_WB0) || (state == S_WB1);
  assign mem_bfirst = data_beat ? (bcnt == '0) : 1'b1;
  assign mem_blen   = data_beat ? blen_d : LW'(1);
  assign mem_be     = (state != S_WR || nb == 3'd4) ? 4'hf : 4'((5'd1 << nb) - 5'd1);

  always_comb begin
    case (state)
      S_HDR:        mem_addr = daddr + {28'd0, hidx, 2'b00};
      S_RD, S_WR:   mem_addr = {ba_w[31:2], 2'b00} + dn;
      S_WB1:        mem_addr = daddr + 32'd4;
      default:      mem_addr = daddr;
    endcase
    case (state)
      S_WB0:   mem_wdata = st_w & 32'h7fff_ffff;
      S_WB1:   mem_wdata = sz_w;
      default: mem_wdata = wbuf;
    endcase
  end

  assign tx_valid = (state == S_TX);
  assign tx_data  = wbuf[{bidx, 3'b000} +: 8];
  assign rx_ready = (state == S_RX);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      daddr <= '0; rem <= '0; st_w <= '0; sz_w <= '0; ba_w <= '0; nx_w <= '0;
      xfer <= '0; dn <= '0; wbuf <= '0; hidx <= '0; bidx <= '0; bcnt <= '0;
      dir <= 1'b0; done <= 1'b0;
      flag_data <= 1'b0; flag_sdio <= 1'b0; flag_sum <= 1'b0;
      flag_tx <= 1'b0; flag_rx <= 1'b0;
    end else begin
      done <= 1'b0;
      if (data_beat && mem_ack)
        bcnt <= (bcnt == '0) ? blen_d - LW'(1) : bcnt - LW'(1);
      case (state)
        S_IDLE: if (go) begin
          daddr <= cfg_base;
          rem   <= cfg_bytes;
          dir   <= cfg_to_card;
          hidx  <= '0;
          flag_data <= 1'b0; flag_sdio <= 1'b0; flag_sum <= 1'b0;
          flag_tx <= 1'b0; flag_rx <= 1'b0;
          state <= cfg_to_card ? S_HDR : S_WAIT;
        end
        S_WAIT: if (card_rdy) state <= S_HDR;
        S_HDR: if (mem_ack) begin
          hidx <= hidx + 2'd1;
          case (hidx)
            2'd0: st_w <= mem_rdata;
            2'd1: sz_w <= (mem_rdata == 32'd0 || mem_rdata > MAXV) ? MAXV : mem_rdata;
            2'd2: ba_w <= mem_rdata;
            default: begin
              nx_w  <= mem_rdata;
              xfer  <= (sz_w < rem) ? sz_w : rem;
              dn    <= '0;
              bcnt  <= '0;
              bidx  <= '0;
              wbuf  <= '0;
              state <= dir ? S_RD : S_RX;
            end
          endcase
        end
        S_RD: if (mem_ack) begin
          wbuf  <= mem_rdata;
          bidx  <= '0;
          state <= S_TX;
        end
        S_TX: if (tx_ready) begin
          if (last_byte) begin
            dn    <= dn_nx;
            state <= (dn_nx == xfer) ? S_WB0 : S_RD;
          end else bidx <= bidx + 2'd1;
        end
        S_RX: if (rx_valid) begin
          wbuf[{bidx, 3'b000} +: 8] <= rx_data;
          if (last_byte) state <= S_WR;
          else bidx <= bidx + 2'd1;
        end
        S_WR: if (mem_ack) begin
          dn    <= dn_nx;
          bidx  <= '0;
          wbuf  <= '0;
          state <= (dn_nx == xfer) ? S_WB0 : S_RX;
        end
        S_WB0: if (mem_ack) state <= S_WB1;
        S_WB1: if (mem_ack) begin
          rem <= rem - xfer;
          if (st_w[2] || rem == xfer) begin
            state <= S_IDLE;
            done  <= 1'b1;
            flag_data <= 1'b1; flag_sdio <= 1'b1; flag_sum <= 1'b1;
            flag_tx <= dir; flag_rx <= !dir;
          end else begin
            daddr <= nx_w;
            hidx  <= '0;
            state <= S_HDR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_dma_walker_chk.sv
module sg_dma_walker_chk #(
  parameter int BEATS = 256,
  parameter int LW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          flag_data,
  input logic          flag_sdio,
  input logic          flag_sum,
  input logic          flag_tx,
  input logic          flag_rx,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic [3:0]    mem_be,
  input logic          mem_bfirst,
  input logic [LW-1:0] mem_blen,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_ready
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid && !rx_ready); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && flag_data && flag_sdio && flag_sum && (flag_tx != flag_rx)); // R10
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_bfirst |-> mem_blen != '0 && mem_blen <= LW'(BEATS)); // R12
  AST_WRITE_BE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R8
endmodule

bind sg_dma_walker sg_dma_walker_chk #(.BEATS(BURST_BYTES / 4), .LW($clog2(BURST_BYTES / 4 + 1))) u_chk (.*);

// File: tb/sg_dma_walker_tb.sv
module sg_dma_walker_tb;
  localparam int MAXD = 64;
  localparam int BB   = 16;
  localparam int LW   = $clog2(BB / 4 + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cfg_en = 1, cfg_to_card = 1, card_rdy = 1;
  logic [31:0] cfg_base = 0, cfg_bytes = 0;
  logic [15:0] cfg_blksz = 16'd512;
  logic mem_req, mem_we, mem_bfirst, tx_valid, rx_ready, busy, done;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic [LW-1:0] mem_blen;
  logic mem_ack;
  logic [31:0] mem_rdata;
  logic [7:0] tx_data, rx_data;
  logic tx_ready, rx_valid;
  logic flag_data, flag_sdio, flag_sum, flag_tx, flag_rx;

  always #4 clk = ~clk;

  sg_dma_walker #(.MAX_DESC(MAXD), .BURST_BYTES(BB), .BLKW(16)) u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mw [0:1023];
  logic ack_r = 0, mem_init = 0, bw_en = 0, rx_clr = 0;
  logic [31:0] rd_r = 0, bw_addr = 0, bw_data = 0;
  int rxi = 0;
  logic [7:0] txb [0:1023];
  int txn = 0, nreq = 0, nbeat = 0, nfirst = 0, blsum = 0, ndone = 0;

  function automatic logic [7:0] patm(input int a); return 8'((a * 7 + 3) & 255); endfunction
  function automatic logic [7:0] patr(input int i); return 8'((i * 13 + 5) & 255); endfunction
  function automatic int dadr(input int i); return 32'h20 + ((i * 3) % 4) * 16; endfunction
  function automatic int badr(input int i); return 32'h400 + i * 128 + ((i + 1) % 4); endfunction
  function automatic logic [7:0] mbyte(input int a); return mw[a >> 2][(a % 4) * 8 +: 8]; endfunction

  assign mem_ack   = ack_r;
  assign mem_rdata = rd_r;
  assign tx_ready  = (cyc % 3) != 1;
  assign rx_valid  = (cyc % 4) != 2;
  assign rx_data   = patr(rxi);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_init) begin
      for (int i = 0; i < 1024; i++)
        mw[i] <= {patm(4*i+3), patm(4*i+2), patm(4*i+1), patm(4*i)};
    end else if (bw_en) mw[bw_addr[11:2]] <= bw_data;
    if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mw[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else rd_r <= mw[mem_addr[11:2]];
    end else ack_r <= 1'b0;
    if (rx_clr) rxi <= 0;
    else if (rx_valid && rx_ready) rxi <= rxi + 1;
  end

  always @(posedge clk) begin
    if (mem_req) nreq++;
    if (mem_req && mem_ack) begin
      nbeat++;
      if (mem_bfirst) begin nfirst++; blsum += int'(mem_blen); end
    end
    if (tx_valid && tx_ready) begin txb[txn] = tx_data; txn++; end
    if (done) ndone++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 190000) begin
    checks++; errors++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    summary();
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    txn = 0; nreq = 0; nbeat = 0; nfirst = 0; blsum = 0; ndone = 0;
  endtask

  task automatic wr_word(input int a, input int d);
    @(negedge clk); bw_en = 1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic try_ignored(input bit en, input int bytes, input int blk, input string what);
    clear_mon();
    cfg_en = en; cfg_bytes = bytes; cfg_blksz = 16'(blk); cfg_base = dadr(0); cfg_to_card = 1;
    pulse_start();
    repeat (10) @(negedge clk);
    check(!busy && nreq == 0, what, nreq, 0);
    cfg_en = 1; cfg_blksz = 16'd512;
  endtask

  int dsz [0:3];

  task automatic run(input bit dir, input int nd, input int s0, input int s1, input int s2,
                     input int s3, input int bytes, input string dtag,
                     input bit hold_rdy, input bit poke);
    int rem, tot, vis, efirst, ewords, k, x, sz, ab, w;
    int xs [0:3];
    bit ok;
    int wd;
    dsz[0] = s0; dsz[1] = s1; dsz[2] = s2; dsz[3] = s3;
    @(negedge clk); mem_init = 1;
    @(negedge clk); mem_init = 0;
    for (int i = 0; i < nd; i++) begin
      wr_word(dadr(i),     32'h8000_0110 | ((i == nd - 1) ? 32'h4 : 32'h0));
      wr_word(dadr(i) + 4, dsz[i]);
      wr_word(dadr(i) + 8, badr(i));
      wr_word(dadr(i) + 12, dadr(i + 1));
    end
    @(negedge clk); rx_clr = 1;
    @(negedge clk); rx_clr = 0;
    clear_mon();
    card_rdy = !hold_rdy;
    cfg_to_card = dir; cfg_base = dadr(0); cfg_bytes = bytes;
    pulse_start();
    if (hold_rdy) begin
      repeat (30) @(negedge clk);
      check(busy && nreq == 0, "R7 waits for card ready", nreq, 0);
      check(!flag_data && !flag_sum && !flag_tx && !flag_rx, "R10 flags cleared on start",
            {flag_data, flag_sum, flag_tx, flag_rx}, 0);
      card_rdy = 1;
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      cfg_base = dadr(1); cfg_bytes = 5; cfg_to_card = !dir;
      pulse_start();
      cfg_base = dadr(0); cfg_bytes = bytes; cfg_to_card = dir;
    end
    wd = 0;
    while (ndone == 0 && wd < 20000) begin @(negedge clk); wd++; end
    repeat (20) @(negedge clk);

    rem = bytes; tot = 0; vis = 0; efirst = 0; ewords = 0;
    for (int i = 0; i < nd; i++) begin
      sz = (dsz[i] == 0 || dsz[i] > MAXD) ? MAXD : dsz[i];
      x = (sz < rem) ? sz : rem;
      xs[i] = x; tot += x; vis = i + 1; rem -= x;
      w = (x + 3) / 4; ewords += w;
      efirst += 6 + (w + BB / 4 - 1) / (BB / 4);
      if (i == nd - 1 || rem == 0) break;
    end

    check(ndone == 1 && !busy, "R10 single done pulse, idle after", ndone, 1);
    check(flag_data && flag_sdio && flag_sum && flag_tx == dir && flag_rx == !dir,
          "R10 completion flags", {flag_data, flag_sdio, flag_sum, flag_tx, flag_rx},
          {3'b111, dir, !dir});
    check((dir ? txn : rxi) == tot, "R2 total bytes moved", dir ? txn : rxi, tot);

    ok = 1; k = 0;
    for (int i = 0; i < vis; i++) begin
      ab = badr(i) & ~3;
      for (int j = 0; j < xs[i]; j++) begin
        if (dir) begin
          if (k < txn && txb[k] != patm(ab + j)) ok = 0;
        end else if (mbyte(ab + j) != patr(k)) ok = 0;
        k++;
      end
      if (!dir && mbyte(ab + xs[i]) != patm(ab + xs[i])) ok = 0;
    end
    check(ok, dir ? {dtag, " R8 card byte stream"} : {dtag, " R9 memory bytes"}, ok, 1);

    ok = 1;
    for (int i = 0; i < nd; i++) begin
      if (mw[dadr(i) >> 2][31] != (i >= vis)) ok = 0;
      if (mw[dadr(i) >> 2][30:0] != (31'h0000_0110 | ((i == nd - 1) ? 31'h4 : 31'h0))) ok = 0;
    end
    check(ok, "R1 ownership cleared exactly on visited chain", vis, vis);

    ok = 1;
    for (int i = 0; i < nd; i++) begin
      sz = (i < vis) ? ((dsz[i] == 0 || dsz[i] > MAXD) ? MAXD : dsz[i]) : dsz[i];
      if (mw[(dadr(i) >> 2) + 1] != sz) ok = 0;
      if (mw[(dadr(i) >> 2) + 2] != badr(i)) ok = 0;
      if (mw[(dadr(i) >> 2) + 3] != dadr(i + 1)) ok = 0;
    end
    check(ok, "R5 writeback of size, other words kept", ok, 1);

    check(nfirst == efirst && blsum == nbeat && nbeat == 6 * vis + ewords,
          "R12 burst count and lengths", nfirst, efirst);
    if (poke)
      check(nreq != 0 && !busy && (dir ? txn : rxi) == tot, "R11 start while busy ignored",
            dir ? txn : rxi, tot);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !tx_valid && !rx_ready &&
          !flag_data && !flag_sum && !flag_tx && !flag_rx, "R10 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    try_ignored(0, 16, 512, "R6 enable low ignored");
    try_ignored(1, 0, 512, "R6 zero byte count ignored");
    try_ignored(1, 16, 0, "R6 zero block size ignored");
    for (int b = 1; b <= 16; b++) run(1, 2, 5, 9, 0, 0, b, "R4", 0, 0);
    run(1, 2, 0, 70, 0, 0, 200, "R3", 0, 0);
    run(1, 3, 64, 65, 1, 0, 130, "R3", 0, 0);
    for (int b = 1; b <= 12; b++) run(0, 3, 3, 6, 0, 0, b, "R4", 0, 0);
    run(0, 3, 3, 6, 0, 0, 100, "R3", 0, 0);
    run(0, 1, 10, 0, 0, 0, 10, "R7", 1, 0);
    run(1, 2, 20, 20, 0, 0, 40, "R11", 0, 1);
    run(0, 4, 7, 1, 2, 5, 15, "R1", 0, 0);
    summary();
  end
endmodule